// File: doc/BRIEF.md
# Print Engine Command/Status Serial Link

This block carries single bytes between a controller and a laser print engine over a slow serial channel. The host side hands over a command byte with a valid/ready handshake. It receives each status byte from the engine as a parallel word with a one-cycle valid strobe. On the engine side the block raises a command-busy flag while it shifts a command out. It watches a status-busy flag that the engine raises when it has a status byte to return. It moves the bits with a serial clock that runs only while a transfer is in progress.

Two configuration inputs set how the link is wired. The first picks the source of the serial clock. The block can divide the system clock and drive the clock pin, or it can take the clock from the engine, pass it through a two-flop synchronizer and detect its edges. The second picks the data wiring. The link can use a separate command output and status input, or one bidirectional line that the block drives only while a command is being sent. Pad buffers are not part of the block and appear as enable outputs.

Top module: `engine_cmd_link`

## Requirements
- R1: After reset, `cbsy`, `sclk_o`, `sd_oe`, `done` and `sts_valid` are low, `cmd_ready` is high, `cmd_o` is high (idle level) and `sts_data` is zero.
- R2: `cmd_ready` is high only while no transfer is running. A cycle with `cmd_valid` and `cmd_ready` both high loads `cmd_data`, and `cbsy` is high from the next cycle until the command byte is finished.
- R3: A command byte goes out most-significant bit first in exactly 8 serial clock pulses. Each bit is presented before the rising edge of its pulse and is replaced only after the falling edge. In separate-line mode the bits appear on `cmd_o`, which rests high when no command is running.
- R4: The serial clock output stays low whenever no transfer is running.
- R5: With the local clock (`cfg_clk_ext` = 0), each high phase and each low phase of `sclk_o` lasts `cfg_div`+1 system clock cycles. The first rising edge comes `cfg_div`+1 cycles after the transfer starts.
- R6: With `cfg_clk_ext` = 1, `sclk_oe` is low and `sclk_i` passes through two synchronizing flip-flops before its edges are used. `sclk_oe` is high when `cfg_clk_ext` = 0. Edges on `sclk_i` while the link is idle have no effect.
- R7: When the synchronized `sbsy` is high in an idle cycle with no command offered, a status transfer starts. 8 bits are sampled MSB first on the rising serial clock edges. After the 8th falling edge, `sts_valid` pulses for one cycle and `sts_data` holds the byte until the next status byte completes.
- R8: With `cfg_shared` = 1, `sd_oe` is high exactly while a command is being sent, `sd_o` carries the command bits, and status bits are taken from `sd_i`. With `cfg_shared` = 0, `sd_oe` stays low and status bits are taken from `sts_i`.
- R9: If a command is offered and the synchronized status request is pending in the same idle cycle, the command is served first. The status transfer starts in a later idle cycle.
- R10: `cbsy` falls in the cycle after the 8th falling serial clock edge of a command, and `done` is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_ext | input | 1 | 1: engine supplies the serial clock; 0: the block generates it |
| cfg_shared | input | 1 | 1: command and status share one bidirectional line |
| cfg_div | input | DIV_W | Local serial clock half-period, in system cycles, minus one |
| cmd_data | input | DATA_W | Command byte offered by the host |
| cmd_valid | input | 1 | Host offers a command byte |
| cmd_ready | output | 1 | Link idle; a command can be accepted |
| done | output | 1 | One-cycle pulse when a command byte has been sent |
| sts_data | output | DATA_W | Last received status byte |
| sts_valid | output | 1 | One-cycle pulse when a status byte has been received |
| cbsy | output | 1 | Command-busy flag to the engine |
| sbsy | input | 1 | Status-busy flag from the engine |
| sclk_o | output | 1 | Locally generated serial clock |
| sclk_oe | output | 1 | Drive enable of the serial clock pad |
| sclk_i | input | 1 | Serial clock from the pad (engine-supplied mode) |
| cmd_o | output | 1 | Command data line (separate-line mode) |
| sts_i | input | 1 | Status data line (separate-line mode) |
| sd_o | output | 1 | Shared data line, outgoing value |
| sd_oe | output | 1 | Drive enable of the shared data pad |
| sd_i | input | 1 | Shared data line, incoming value |

## Verification
The hardest case to reach is the idle cycle in which a command offer and an already synchronized status request are both present. Because `sbsy` passes through two flops, raising it together with `cmd_valid` never gives a real conflict. The bench first starts a command. While that command is still shifting, it raises `sbsy` and offers a second command, so both requests wait for the same idle cycle. The bench then confirms that the second command begins before any status clocking. A second corner case is stray engine clock edges while idle in engine-clock mode. These are followed by a full command, which must still take exactly 8 pulses.

// File: rtl/engine_cmd_link.sv
module engine_cmd_link #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_clk_ext,
  input  logic              cfg_shared,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  output logic              done,
  output logic [DATA_W-1:0] sts_data,
  output logic              sts_valid,
  output logic              cbsy,
  input  logic              sbsy,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              sclk_i,
  output logic              cmd_o,
  input  logic              sts_i,
  output logic              sd_o,
  output logic              sd_oe,
  input  logic              sd_i
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  typedef enum logic [1:0] {IDLE, SEND, RECV} st_t;

  st_t               st;
  logic [DATA_W-1:0] sh;
  logic [CW-1:0]     bcnt;
  logic [DIV_W-1:0]  div_cnt;
  logic              sclk_q;
  logic [2:0]        ck_sy;
  logic [1:0]        sb_sy;
  logic              busy, tick, rise, fall, txd, rxd;

  assign busy      = (st != IDLE);
  assign tick      = busy && !cfg_clk_ext && (div_cnt == cfg_div);
  assign rise      = busy && (cfg_clk_ext ? (ck_sy[1] & ~ck_sy[2]) : (tick & ~sclk_q));
  assign fall      = busy && (cfg_clk_ext ? (~ck_sy[1] & ck_sy[2]) : (tick & sclk_q));
  assign txd       = (st == SEND) ? sh[DATA_W-1] : 1'b1;
  assign rxd       = cfg_shared ? sd_i : sts_i;
  assign cmd_ready = (st == IDLE);
  assign cbsy      = (st == SEND);
  assign sclk_o    = sclk_q;
  assign sclk_oe   = !cfg_clk_ext;
  assign cmd_o     = cfg_shared ? 1'b1 : txd;
  assign sd_o      = txd;
  assign sd_oe     = cfg_shared && (st == SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sy <= '0;
      sb_sy <= '0;
    end else begin
      ck_sy <= {ck_sy[1:0], sclk_i};
      sb_sy <= {sb_sy[0], sbsy};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      sh        <= '0;
      bcnt      <= '0;
      div_cnt   <= '0;
      sclk_q    <= 1'b0;
      done      <= 1'b0;
      sts_valid <= 1'b0;
      sts_data  <= '0;
    end else begin
      done      <= 1'b0;
      sts_valid <= 1'b0;
      if (st == IDLE) begin
        div_cnt <= '0;
        sclk_q  <= 1'b0;
        bcnt    <= '0;
        if (cmd_valid) begin
          st <= SEND;
          sh <= cmd_data;
        end else if (sb_sy[1]) begin
          st <= RECV;
          sh <= '0;
        end
      end else begin
        if (!cfg_clk_ext) begin
          div_cnt <= tick ? '0 : div_cnt + 1'b1;
          if (tick) sclk_q <= ~sclk_q;
        end
        if (rise && st == RECV) sh <= {sh[DATA_W-2:0], rxd};
        if (fall) begin
          if (st == SEND) sh <= {sh[DATA_W-2:0], 1'b0};
          if (bcnt == LAST) begin
            st <= IDLE;
            if (st == SEND) begin
              done <= 1'b1;
            end else begin
              sts_valid <= 1'b1;
              sts_data  <= sh;
            end
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
      end
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> cbsy);

  // R3
  hold_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(txd));

  // R4
  gated_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> busy);

  // R6
  ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk_ext |-> !sclk_o);

  // R7
  sts_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |=> !sts_valid);

  // R9
  cmd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && cmd_valid && sb_sy[1]) |=> cbsy);

  // R10
  done_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cbsy) |-> done);
endmodule

// File: tb/test_engine_cmd_link.sv
module test_engine_cmd_link;
  localparam int DW = 8;
  localparam int VW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cfg_clk_ext = 1'b0;
  logic          cfg_shared  = 1'b0;
  logic [VW-1:0] cfg_div     = 8'd1;
  logic [DW-1:0] cmd_data    = '0;
  logic          cmd_valid   = 1'b0;
  logic          sbsy        = 1'b0;
  logic          sclk_i      = 1'b0;
  logic          eng_bit     = 1'b1;
  wire           sts_i = cfg_shared ? ~eng_bit : eng_bit;
  wire           sd_i  = cfg_shared ? eng_bit : ~eng_bit;

  logic cmd_ready, done, sts_valid, cbsy, sclk_o, sclk_oe, cmd_o, sd_o, sd_oe;
  logic [DW-1:0] sts_data;

  engine_cmd_link #(.DATA_W(DW), .DIV_W(VW)) i_engine_cmd_link (
    .clk(clk), .rst_n(rst_n), .cfg_clk_ext(cfg_clk_ext), .cfg_shared(cfg_shared),
    .cfg_div(cfg_div), .cmd_data(cmd_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .done(done), .sts_data(sts_data), .sts_valid(sts_valid), .cbsy(cbsy), .sbsy(sbsy),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i), .cmd_o(cmd_o), .sts_i(sts_i),
    .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i)
  );

  int tests = 0, fails = 0, cyc = 0, sv_cnt = 0;
  int rx_n = 0, hi_run = 0, last_high = 0;
  logic [7:0] rx_sh = '0;
  logic [7:0] exp_cmd[$];
  logic [7:0] exp_sts[$];

  task automatic cmp(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: mode 0 idle, 1 sending, 2 receiving
  int m_mode = 0, m_wait = 0, m_bits = 0;
  bit m_clk = 0, m_done = 0, m_sv = 0, er, ef, mr, mf, sbs;
  bit [7:0] m_cmd = 0, m_rx = 0, m_sd = 0;
  bit [2:0] m_ck = 0;
  bit [1:0] m_sb = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_wait = 0; m_bits = 0; m_clk = 0; m_done = 0; m_sv = 0;
      m_sd = 0; m_ck = 0; m_sb = 0;
    end else begin
      er = m_ck[1] & ~m_ck[2];
      ef = ~m_ck[1] & m_ck[2];
      sbs = m_sb[1];
      m_done = 0;
      m_sv = 0;
      if (m_mode == 0) begin
        m_wait = 0; m_clk = 0; m_bits = 0;
        if (cmd_valid) begin m_mode = 1; m_cmd = cmd_data; end
        else if (sbs) begin m_mode = 2; m_rx = 0; end
      end else begin
        mr = 0; mf = 0;
        if (cfg_clk_ext) begin mr = er; mf = ef; end
        else if (m_wait == int'(cfg_div)) begin
          m_wait = 0; mr = !m_clk; mf = m_clk; m_clk = !m_clk;
        end else m_wait++;
        if (mr && m_mode == 2) m_rx = {m_rx[6:0], (cfg_shared ? sd_i : sts_i)};
        if (mf) begin
          m_bits++;
          if (m_bits == 8) begin
            if (m_mode == 1) m_done = 1;
            else begin m_sv = 1; m_sd = m_rx; end
            m_mode = 0;
          end
        end
      end
      m_ck = {m_ck[1:0], sclk_i};
      m_sb = {m_sb[0], sbsy};
    end
  end

  // engine-side receiver for the local clock
  always @(posedge sclk_o) if (cbsy) begin
    rx_sh = {rx_sh[6:0], (cfg_shared ? sd_o : cmd_o)};
    rx_n++;
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    if (rst_n) begin
      logic etx;
      etx = (m_mode == 1 && m_bits < 8) ? m_cmd[7 - m_bits] : 1'b1;
      cmp(cbsy == (m_mode == 1), "R2 cbsy", cbsy, m_mode == 1);
      cmp(cmd_ready == (m_mode == 0), "R2 cmd_ready", cmd_ready, m_mode == 0);
      cmp(sclk_o == m_clk, "R5 sclk_o", sclk_o, m_clk);
      cmp(!(sclk_o && m_mode == 0), "R4 idle clock", sclk_o, 0);
      cmp(sclk_oe == !cfg_clk_ext, "R6 sclk_oe", sclk_oe, !cfg_clk_ext);
      cmp(sd_oe == (cfg_shared && m_mode == 1), "R8 sd_oe", sd_oe, cfg_shared && m_mode == 1);
      cmp(cmd_o == (cfg_shared ? 1'b1 : etx), "R3 cmd_o", cmd_o, cfg_shared ? 1'b1 : etx);
      if (cfg_shared && m_mode == 1) cmp(sd_o == etx, "R8 sd_o", sd_o, etx);
      cmp(done == m_done, "R10 done", done, m_done);
      cmp(sts_valid == m_sv, "R7 sts_valid", sts_valid, m_sv);
      cmp(sts_data == m_sd, "R7 sts_data", sts_data, m_sd);
      if (sclk_o) hi_run++;
      else if (hi_run > 0) begin last_high = hi_run; hi_run = 0; end
      if (done) begin
        logic [7:0] e;
        e = (exp_cmd.size() > 0) ? exp_cmd.pop_front() : 8'hxx;
        cmp(rx_n == 8, "R3 pulse count", rx_n, 8);
        cmp(rx_sh === e, "R3 command byte at engine", rx_sh, e);
        rx_n = 0;
      end
      if (sts_valid) begin
        logic [7:0] e;
        sv_cnt++;
        e = (exp_sts.size() > 0) ? exp_sts.pop_front() : 8'hxx;
        cmp(sts_data === e, "R7 status byte", sts_data, e);
      end
    end
  end

  task automatic send_cmd(input logic [7:0] b);
    bit rdy;
    exp_cmd.push_back(b);
    cmd_data = b;
    cmd_valid = 1'b1;
    forever begin
      rdy = cmd_ready;
      @(negedge clk);
      if (rdy) break;
    end
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic int_status_track(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(posedge sclk_o);
      if (i == 7) sbsy = 1'b0;
      @(negedge sclk_o);
      if (i < 7) eng_bit = b[6 - i];
    end
    eng_bit = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic int_status(input logic [7:0] b);
    exp_sts.push_back(b);
    eng_bit = b[7];
    sbsy = 1'b1;
    int_status_track(b);
  endtask

  task automatic ext_send(input logic [7:0] b);
    send_cmd(b);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_sh = {rx_sh[6:0], (cfg_shared ? sd_o : cmd_o)};
      rx_n++;
      sclk_i = 1'b1;
      repeat (6) @(negedge clk);
      sclk_i = 1'b0;
      repeat (6) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic ext_status(input logic [7:0] b);
    exp_sts.push_back(b);
    eng_bit = b[7];
    sbsy = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sclk_i = 1'b1;
      if (i == 7) sbsy = 1'b0;
      repeat (6) @(negedge clk);
      sclk_i = 1'b0;
      if (i < 7) eng_bit = b[6 - i];
      repeat (6) @(negedge clk);
    end
    eng_bit = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int sv_before;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cmp(!cbsy && cmd_ready && !sclk_o && !sd_oe && !done && !sts_valid && cmd_o && sts_data == 0,
        "R1 reset state", {cbsy, cmd_ready, sclk_o, sd_oe, done, sts_valid, cmd_o}, 7'b0100001);

    cfg_div = 8'd1;
    send_cmd(8'hA5); wait_done();
    cfg_div = 8'd3;
    send_cmd(8'h3C); wait_done();
    repeat (2) @(negedge clk);
    cmp(last_high == 4, "R5 high phase with divider 3", last_high, 4);

    cfg_div = 8'd2;
    int_status(8'hC3);
    cfg_div = 8'd0;
    send_cmd(8'h81);
    send_cmd(8'h7E); wait_done();
    repeat (2) @(negedge clk);

    cfg_shared = 1'b1; cfg_div = 8'd2;
    send_cmd(8'h96); wait_done();
    int_status(8'h69);

    // R9: command offered while the status request is already synchronized
    cfg_shared = 1'b0;
    send_cmd(8'h12);
    exp_sts.push_back(8'hB4);
    eng_bit = 1'b1;
    sbsy = 1'b1;
    sv_before = sv_cnt;
    fork
      send_cmd(8'hED);
      begin
        wait_done();
        @(negedge clk);
        cmp(cbsy == 1'b1, "R9 command served before status", cbsy, 1);
      end
    join
    wait_done();
    cmp(sv_cnt == sv_before, "R9 no status before second command", sv_cnt, sv_before);
    int_status_track(8'hB4);

    // R6: engine clock, stray edges while idle
    cfg_clk_ext = 1'b1;
    repeat (2) @(negedge clk);
    sv_before = sv_cnt;
    for (int i = 0; i < 3; i++) begin
      sclk_i = 1'b1; repeat (3) @(negedge clk);
      sclk_i = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    cmp(cmd_ready && !cbsy && sv_cnt == sv_before, "R6 idle edges ignored",
        {cmd_ready, cbsy}, 2'b10);
    ext_send(8'h5A);
    ext_status(8'hA6);

    cfg_shared = 1'b1;
    repeat (2) @(negedge clk);
    ext_send(8'hF0);
    ext_status(8'h0F);
    repeat (4) @(negedge clk);

    cmp(exp_cmd.size() == 0, "R10 every command completed", exp_cmd.size(), 0);
    cmp(exp_sts.size() == 0 && sv_cnt == 5, "R7 every status delivered", sv_cnt, 5);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule